// File: doc/BRIEF.md
# Set/Clear Programmable GPIO Controller

This block controls 32 general-purpose pins, split into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). Each pin has eight per-pin control bits: output value, input enable, output enable, open-drain mode, pull-up, pull-down, input inversion and output inversion. Each of these features has its own 16-bit register in each bank. The high bank repeats the register layout of the low bank at a fixed address offset.

Software never needs a read-modify-write. Every write is a 32-bit word: bits 15:0 select pins to set and bits 31:16 select pins to clear, so a single pin can change without disturbing any other. The block turns the register state into pad controls. These are the driven level, the drive enable (which respects open-drain mode), and the pull-up and pull-down requests. It also presents the conditioned pad input for software to read.

Top module: `gpio_sc_ctrl`

## Requirements
- R1: A write with bit n (n < 16) set in wdata sets bit n of the addressed feature register. Every bit whose set and clear bits are both zero keeps its value.
- R2: A write with bit n+16 set in wdata clears bit n of the addressed feature register.
- R3: When one word carries both the set bit and the clear bit for the same pin, that pin's bit ends up cleared.
- R4: Address bit 6 selects the bank: 0x00 is the low bank and 0x40 is the high bank. Register bit n of the high bank controls pin 16+n.
- R5: Feature register offsets within a bank are 0x00 output value, 0x04 input enable, 0x08 output enable, 0x0C open drain, 0x10 pull-up, 0x14 pull-down, 0x18 input invert and 0x1C output invert. A read returns the register in rdata[15:0], and rdata[31:16] always reads as zero.
- R6: The driven level pad_out[p] equals output value XOR output invert. pad_oe[p] is 0 whenever output enable is 0.
- R7: When output enable is 1, pad_oe[p] is 1 in push-pull mode (open drain 0). In open-drain mode it is 1 only when the driven level is 0.
- R8: A read of offset 0x20 in a bank returns, for each pin, (pad_in XOR input invert) AND input enable in bits 15:0.
- R9: pad_pu[p] and pad_pd[p] follow the pull-up and pull-down register bits of pin p.
- R10: After reset every register is zero, so all pad outputs are zero. Writes to offset 0x20, to offsets 0x24 to 0x3C, or to addresses with addr[1:0] nonzero change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 7 | Byte address: bank in bit 6, register in bits 5:2 |
| wdata | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| rdata | output | 32 | Read data of the register at addr (combinational) |
| pad_in | input | 32 | Sampled pad levels |
| pad_out | output | 32 | Level to drive on each pad |
| pad_oe | output | 32 | Drive enable for each pad |
| pad_pu | output | 32 | Pull-up request for each pad |
| pad_pd | output | 32 | Pull-down request for each pad |

## Verification
The set and the clear of one pin can fall in the same write, and so can a set of one pin and a clear of its neighbour. For every bank, feature and pin, the bench issues a word carrying both bits after first setting the pin. It expects a cleared bit. It also checks that the other fifteen bits of that register match an arithmetic model. The pad sweep changes the output-value, inversion, enable and open-drain bits of one pin so that drive level and drive enable flip together. Each result is judged against the formula in R6 and R7.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // Feature register index inside a bank (address bits 5:2)
  typedef enum logic [3:0] {
    FT_OUTV   = 4'd0,
    FT_INEN   = 4'd1,
    FT_OUTEN  = 4'd2,
    FT_OD     = 4'd3,
    FT_PU     = 4'd4,
    FT_PD     = 4'd5,
    FT_ININV  = 4'd6,
    FT_OUTINV = 4'd7,
    FT_INVAL  = 4'd8
  } feat_e;

  localparam int NUM_FEAT = 8;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode #(
  parameter int ADDR_W    = 7,
  parameter int NUM_BANKS = 2,
  parameter int NUM_FEAT  = 8
) (
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  output logic [NUM_BANKS*NUM_FEAT-1:0] wr_sel
);
  localparam int REG_LSB  = 2;
  localparam int REG_W    = 4;
  localparam int BANK_LSB = REG_LSB + REG_W;

  logic [REG_W-1:0]           reg_idx;
  logic [ADDR_W-BANK_LSB-1:0] bank_idx;
  logic                       aligned;

  assign reg_idx  = addr[BANK_LSB-1:REG_LSB];
  assign bank_idx = addr[ADDR_W-1:BANK_LSB];
  assign aligned  = (addr[REG_LSB-1:0] == '0);

  always_comb begin
    wr_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int f = 0; f < NUM_FEAT; f++) begin
        if (wr_en && aligned && (int'(bank_idx) == b) && (int'(reg_idx) == f))
          wr_sel[b*NUM_FEAT+f] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = (q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_nxt;
  end

  // R1
  set_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));
  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & $past(clr_mask)) == '0));
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_sc_pad.sv
module gpio_sc_pad #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] outv,
  input  logic [W-1:0] outinv,
  input  logic [W-1:0] outen,
  input  logic [W-1:0] od,
  input  logic [W-1:0] inen,
  input  logic [W-1:0] ininv,
  input  logic [W-1:0] pin,
  output logic [W-1:0] pout,
  output logic [W-1:0] poe,
  output logic [W-1:0] inval
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl;
    assign lvl      = outv[i] ^ outinv[i];
    assign pout[i]  = lvl;
    assign poe[i]   = outen[i] & (~od[i] | ~lvl);
    assign inval[i] = (pin[i] ^ ininv[i]) & inen[i];

    // R7
    od_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poe[i] && od[i]) |-> !pout[i]);
    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !outen[i] |-> !poe[i]);
  end
endmodule

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  parameter int ADDR_W        = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [2*PINS_PER_BANK-1:0]         wdata,
  output logic [2*PINS_PER_BANK-1:0]         rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_pu,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_pd
);
  localparam int PB       = PINS_PER_BANK;
  localparam int DATA_W   = 2 * PB;
  localparam int BANK_LSB = 6;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [NUM_BANKS*NUM_FEAT-1:0] wr_sel;
  logic [PB-1:0]                 feat_q [NUM_BANKS][NUM_FEAT];
  logic [PB-1:0]                 in_val [NUM_BANKS];

  gpio_sc_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .NUM_FEAT(NUM_FEAT)
  ) i_dec (
    .wr_en(wr_en), .addr(addr), .wr_sel(wr_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
      gpio_sc_reg #(.W(PB)) i_reg (
        .clk(clk), .rst_n(rst_i_n), .we(wr_sel[b*NUM_FEAT+f]),
        .set_mask(wdata[PB-1:0]), .clr_mask(wdata[DATA_W-1:PB]),
        .q(feat_q[b][f])
      );
    end

    gpio_sc_pad #(.W(PB)) i_pad (
      .clk(clk), .rst_n(rst_i_n),
      .outv(feat_q[b][FT_OUTV]),   .outinv(feat_q[b][FT_OUTINV]),
      .outen(feat_q[b][FT_OUTEN]), .od(feat_q[b][FT_OD]),
      .inen(feat_q[b][FT_INEN]),   .ininv(feat_q[b][FT_ININV]),
      .pin(pad_in[b*PB +: PB]),
      .pout(pad_out[b*PB +: PB]),  .poe(pad_oe[b*PB +: PB]),
      .inval(in_val[b])
    );

    assign pad_pu[b*PB +: PB] = feat_q[b][FT_PU];
    assign pad_pd[b*PB +: PB] = feat_q[b][FT_PD];
  end

  // read path
  logic [3:0]                 rd_reg;
  logic [ADDR_W-BANK_LSB-1:0] rd_bank;

  assign rd_reg  = addr[BANK_LSB-1:2];
  assign rd_bank = addr[ADDR_W-1:BANK_LSB];

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(rd_bank) == b && addr[1:0] == 2'b00) begin
        for (int f = 0; f < NUM_FEAT; f++)
          if (int'(rd_reg) == f) rdata[PB-1:0] = feat_q[b][f];
        if (rd_reg == FT_INVAL) rdata[PB-1:0] = in_val[b];
      end
    end
  end

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rdata[DATA_W-1:PB] == '0);
  // R9
  pull_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && addr == 7'h10 && wdata[0] && !wdata[PB]) |=> pad_pu[0]);
endmodule

// File: tb/test_gpio_sc_ctrl.sv
module test_gpio_sc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int tests = 0;
  int fails = 0;
  logic [15:0] expm [2][8];

  always #2.5 clk = ~clk;

  gpio_sc_ctrl i_gpio_sc_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[1:0] == 2'b00 && a[5:2] < 4'd8)
      expm[a[6]][a[4:2]] = (expm[a[6]][a[4:2]] | d[15:0]) & ~d[31:16];
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_regs(input string req);
    logic [31:0] v;
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++) begin
        rd(7'(b*64 + f*4), v);
        chk(req, v, {16'h0, expm[b][f]});
      end
  endtask

  task automatic chk_pads(input string req);
    logic [31:0] eo, eoe, epu, epd;
    for (int g = 0; g < 32; g++) begin
      logic lvl;
      lvl    = expm[g/16][0][g%16] ^ expm[g/16][7][g%16];
      eo[g]  = lvl;
      eoe[g] = expm[g/16][2][g%16] & (~expm[g/16][3][g%16] | ~lvl);
      epu[g] = expm[g/16][4][g%16];
      epd[g] = expm[g/16][5][g%16];
    end
    chk({req, " pad_out"}, pad_out, eo);
    chk({req, " pad_oe"}, pad_oe, eoe);
    chk("R9 pad_pu", pad_pu, epu);
    chk("R9 pad_pd", pad_pd, epd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int b = 0; b < 2; b++) for (int f = 0; f < 8; f++) expm[b][f] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk_regs("R10 reset");
    chk_pads("R10 reset");

    // R1 R2 R3 R4 R5: every bank, feature, pin
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++) begin
        logic [6:0] a;
        a = 7'(b*64 + f*4);
        for (int p = 0; p < 16; p++) begin
          wr(a, 32'(1) << p);
          rd(a, v); chk("R1 set", v, {16'h0, expm[b][f]});
          wr(a, 32'(1) << (p + 16));
          rd(a, v); chk("R2 clear", v, {16'h0, expm[b][f]});
          wr(a, (32'(1) << p) | 32'h0000_5a5a);
          wr(a, (32'(1) << p) | (32'(1) << (p + 16)));
          rd(a, v); chk("R3 clear wins", v, {16'h0, expm[b][f]});
          chk("R3 bit", 32'(v[p]), 32'h0);
        end
        wr(a, 32'hffff_0000);
        chk_regs("R4 bank isolation");
      end

    // R6 R7: pad sweep on pins 3 and 28
    for (int k = 0; k < 2; k++) begin
      int b, p;
      b = k; p = k ? 12 : 3;
      for (int c = 0; c < 16; c++) begin
        wr(7'(b*64 + 0),  c[0] ? 32'(1) << p : 32'(1) << (p + 16));
        wr(7'(b*64 + 28), c[1] ? 32'(1) << p : 32'(1) << (p + 16));
        wr(7'(b*64 + 8),  c[2] ? 32'(1) << p : 32'(1) << (p + 16));
        wr(7'(b*64 + 12), c[3] ? 32'(1) << p : 32'(1) << (p + 16));
        chk("R6 level", 32'(pad_out[b*16+p]), 32'(c[0] ^ c[1]));
        chk("R7 enable", 32'(pad_oe[b*16+p]), 32'(c[2] & (~c[3] | ~(c[0] ^ c[1]))));
        chk_pads("R6 R7 all");
      end
    end

    // R9 pulls
    wr(7'h10, 32'h0000_8001); wr(7'h54, 32'h0000_0300);
    chk_pads("R9 pulls");

    // R8 input path, both banks
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 8; c++) begin
        int p;
        p = 5 + b * 4;
        wr(7'(b*64 + 4),  c[0] ? 32'(1) << p : 32'(1) << (p + 16));
        wr(7'(b*64 + 24), c[1] ? 32'(1) << p : 32'(1) << (p + 16));
        pad_in = c[2] ? 32'hffff_ffff : 32'h0;
        rd(7'(b*64 + 32), v);
        chk("R8 input bit", 32'(v[p]), 32'(c[0] & (c[2] ^ c[1])));
        chk("R8 input word", v,
            {16'h0, (({16{c[2]}}) ^ expm[b][6]) & expm[b][1]});
      end

    // R10 ignored writes
    wr(7'h20, 32'h0000_ffff);
    wr(7'h24, 32'h0000_ffff);
    wr(7'h7c, 32'h0000_ffff);
    wr(7'h01, 32'h0000_ffff);
    wr(7'h42, 32'hffff_0000);
    chk_regs("R10 ignored");
    chk_pads("R10 ignored");
    rd(7'h3c, v); chk("R5 unmapped read", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule